// File: doc/BRIEF.md
# Flash Command Snooper with Lane Bit Striping

This block sits between a controller's transmit and receive byte queues and up to `MAX_LANES` parallel serial-flash byte lanes. It watches the byte stream that follows each chip-select change. The first byte is decoded as a flash instruction, and the address and dummy bytes that the instruction implies are counted off. Once the count runs out, every later transfer is striped: one byte per effective lane is taken from the transmit side and the bits are dealt across the lanes. The bytes returned by the lanes go through the inverse shuffle before they reach the receive side. In every other state a single byte is copied to all effective lanes, and only lane 0's reply is kept.

The controller requests each lane transfer with a one-cycle `xfer_req` pulse. The transmit head is offered as `tx_valid`, with `tx_avail` giving the number of bytes present, up to `MAX_LANES`. The block pops with `tx_ready` and reports the count in `tx_pop_cnt`. It then presents one lane beat and waits for the lane reply. The reply is handed on at once as an `rx_valid` beat. No back-pressure is held on the receive side. If `rx_ready` is low when the reply arrives, the beat is discarded and an overflow event is raised. A request that finds too few transmit bytes pops nothing and raises an underflow event.

Top module: `snp_lane_snooper`

## Requirements
- R1: After reset, `snoop_mode` is 0 (checking), and `lane_out_valid`, `tx_ready`, `ev_tx_underflow` and `ev_rx_overflow` are all 0.
- R2: A `cs_change` pulse sets `snoop_mode` to 0 on the next edge. It wins over a transfer issued in the same cycle, and the next issued byte is then decoded as an instruction.
- R3: In mode 0, an issued instruction sets up a count of bytes to skip: 0x03 skips 3, 0x0B skips 4, 0xBB skips 4 and 0xEB skips 5. While bytes are being skipped the mode is 1. When the last counted byte is issued, the mode becomes 2 (striping) and stays there until `cs_change`.
- R4: Any other instruction sets the mode to 3. Mode 3 never stripes and holds until `cs_change`, whatever bytes follow.
- R5: Outside mode 2, an issued transfer pops one byte (`tx_pop_cnt`=1) and drives it on every effective lane, with non-effective lanes at zero. The received beat carries lane 0's reply in byte 0, zeros above it, and `rx_cnt`=1.
- R6: In mode 2 with two effective lanes, two bytes are popped. Taking the pair P = {byte1, byte0}, bit j of lane k is bit 2j+k of P. That is, lane 0 carries the even bits and lane 1 the odd bits.
- R7: A reply to a striped transfer is de-striped before it is delivered: bit 2j+k of `rx_data` is bit j of lane k's reply, and `rx_cnt`=2. A lane that echoes its input therefore returns the original pair.
- R8: The effective lane count is 2 only when `cfg_sep_bus` and `cfg_two_mem` are both 1, and 1 otherwise. With one lane, mode 2 pops one byte and passes it and its reply through unchanged.
- R9: A request that finds fewer bytes than it needs does not pop and issues no lane beat. It pulses `ev_tx_underflow` one cycle later and leaves the mode unchanged.
- R10: A reply that arrives while `rx_ready` is 0 is dropped, and `ev_rx_overflow` pulses one cycle later. The mode is unaffected.
- R11: `lane_out_valid` rises one cycle after an accepted request. Only one transfer is outstanding at a time: a request made before the reply returns is ignored and pops nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_change | input | 1 | Pulse on any chip-select change |
| cfg_sep_bus | input | 1 | Separate-bus configuration bit |
| cfg_two_mem | input | 1 | Two-memory configuration bit |
| xfer_req | input | 1 | Request one lane transfer |
| tx_valid | input | 1 | Transmit head holds at least one byte |
| tx_avail | input | CW | Bytes available at the transmit head (saturated at MAX_LANES) |
| tx_data | input | 8*MAX_LANES | Head bytes, oldest in bits 7:0 |
| tx_ready | output | 1 | Pop strobe |
| tx_pop_cnt | output | CW | Number of bytes popped |
| lane_out_valid | output | 1 | Lane beat present |
| lane_out_data | output | 8*MAX_LANES | One byte per lane, lane 0 in bits 7:0 |
| lane_in_valid | input | 1 | Lane reply present |
| lane_in_data | input | 8*MAX_LANES | Reply byte per lane |
| rx_valid | output | 1 | Receive beat present |
| rx_ready | input | 1 | Receive side can accept |
| rx_data | output | 8*MAX_LANES | Received bytes, oldest in bits 7:0 |
| rx_cnt | output | CW | Valid byte count in `rx_data` |
| ev_tx_underflow | output | 1 | Transmit underflow pulse |
| ev_rx_overflow | output | 1 | Receive overflow pulse |
| snoop_mode | output | 2 | 0 checking, 1 skipping, 2 striping, 3 none |

## Verification
The bench builds the block with `MAX_LANES` = 2. This makes both the single-lane and the dual-lane behaviour reachable through the two configuration bits, and all four configuration combinations are tried. Every supported instruction is walked through its full skip count. In striping, all 256 values of the low byte are swept, each paired with a derived high byte. The lane words and the echoed round trip are checked against even/odd bit arithmetic computed in the bench. Underflow, overflow, a request made while busy, and a chip-select change that coincides with a transfer are each driven directly.

// File: rtl/snp_pkg.sv
package snp_pkg;
  typedef enum logic [1:0] {
    SNP_CHECK  = 2'd0,
    SNP_COUNT  = 2'd1,
    SNP_STRIPE = 2'd2,
    SNP_NONE   = 2'd3
  } snp_mode_e;

  localparam int SKIP_W = 3;

  typedef struct packed {
    logic              known;
    logic [SKIP_W-1:0] skip;
  } snp_cmd_t;

  // Instruction byte -> number of address plus dummy bytes to let through unstriped
  function automatic snp_cmd_t decode_cmd(input logic [7:0] op);
    snp_cmd_t c;
    c.known = 1'b1;
    case (op)
      8'h03:   c.skip = SKIP_W'(3);
      8'h0B:   c.skip = SKIP_W'(4);
      8'hBB:   c.skip = SKIP_W'(4);
      8'hEB:   c.skip = SKIP_W'(5);
      default: begin c.known = 1'b0; c.skip = '0; end
    endcase
    return c;
  endfunction
endpackage

// File: rtl/snp_striper.sv
module snp_striper #(
  parameter int LANES = 2,
  parameter bit UNDO  = 1'b0
) (
  input  logic [LANES*8-1:0] din,
  output logic [LANES*8-1:0] dout
);
  localparam int NB = LANES * 8;

  generate
    if (LANES == 1) begin : g_pass
      assign dout = din;
    end else begin : g_deal
      for (genvar k = 0; k < NB; k++) begin : g_bit
        // flat bit k goes to lane (k mod LANES), bit position (k div LANES)
        localparam int P = (k % LANES) * 8 + (k / LANES);
        if (!UNDO) begin : g_fwd
          assign dout[P] = din[k];
        end else begin : g_inv
          assign dout[k] = din[P];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/snp_tracker.sv
module snp_tracker
  import snp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_change,
  input  logic       issue,
  input  logic [7:0] opcode,
  output snp_mode_e  mode
);
  logic [SKIP_W-1:0] left_q;
  snp_cmd_t          cmd;

  assign cmd = decode_cmd(opcode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode   <= SNP_CHECK;
      left_q <= '0;
    end else if (cs_change) begin
      mode   <= SNP_CHECK;
      left_q <= '0;
    end else if (issue) begin
      case (mode)
        SNP_CHECK: begin
          if (cmd.known) begin
            mode   <= SNP_COUNT;
            left_q <= cmd.skip;
          end else begin
            mode <= SNP_NONE;
          end
        end
        SNP_COUNT: begin
          if (left_q == SKIP_W'(1)) mode <= SNP_STRIPE;
          left_q <= left_q - SKIP_W'(1);
        end
        default: ;
      endcase
    end
  end

  assert_cs_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_change |=> (mode == SNP_CHECK));
  assert_none_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SNP_NONE && !cs_change) |=> (mode == SNP_NONE));
  assert_stripe_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SNP_STRIPE && !cs_change) |=> (mode == SNP_STRIPE));
  assert_count_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SNP_COUNT) |-> (left_q != '0));
endmodule

// File: rtl/snp_lane_snooper.sv
module snp_lane_snooper
  import snp_pkg::*;
#(
  parameter int MAX_LANES = 2,
  localparam int CW = $clog2(MAX_LANES + 1),
  localparam int DW = MAX_LANES * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_change,
  input  logic          cfg_sep_bus,
  input  logic          cfg_two_mem,
  input  logic          xfer_req,
  input  logic          tx_valid,
  input  logic [CW-1:0] tx_avail,
  input  logic [DW-1:0] tx_data,
  output logic          tx_ready,
  output logic [CW-1:0] tx_pop_cnt,
  output logic          lane_out_valid,
  output logic [DW-1:0] lane_out_data,
  input  logic          lane_in_valid,
  input  logic [DW-1:0] lane_in_data,
  output logic          rx_valid,
  input  logic          rx_ready,
  output logic [DW-1:0] rx_data,
  output logic [CW-1:0] rx_cnt,
  output logic          ev_tx_underflow,
  output logic          ev_rx_overflow,
  output logic [1:0]    snoop_mode
);
  snp_mode_e     mode;
  logic          eff_multi, stripe_now, fire, starved;
  logic          busy_q, striped_q;
  logic [CW-1:0] need;
  logic [DW-1:0] tx_striped, rx_unstriped, repl_w, beat_w;

  // effective lane count: all lanes only with both configuration bits set (R8)
  assign eff_multi  = (MAX_LANES > 1) && cfg_sep_bus && cfg_two_mem;
  assign stripe_now = (mode == SNP_STRIPE);
  assign need       = (stripe_now && eff_multi) ? CW'(MAX_LANES) : CW'(1);

  assign fire    = xfer_req && !busy_q && tx_valid && (tx_avail >= need);
  assign starved = xfer_req && !busy_q && !(tx_valid && (tx_avail >= need));

  assign tx_ready   = fire;
  assign tx_pop_cnt = fire ? need : '0;

  snp_striper #(.LANES(MAX_LANES), .UNDO(1'b0)) u_fwd (
    .din (tx_data),
    .dout(tx_striped)
  );

  snp_striper #(.LANES(MAX_LANES), .UNDO(1'b1)) u_inv (
    .din (lane_in_data),
    .dout(rx_unstriped)
  );

  generate
    for (genvar g = 0; g < MAX_LANES; g++) begin : g_repl
      assign repl_w[g*8 +: 8] = (g == 0 || eff_multi) ? tx_data[7:0] : 8'h00;
    end
  endgenerate

  always_comb begin
    if (stripe_now && eff_multi) beat_w = tx_striped;
    else                         beat_w = repl_w;
  end

  snp_tracker u_trk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_change(cs_change),
    .issue    (fire),
    .opcode   (tx_data[7:0]),
    .mode     (mode)
  );

  assign snoop_mode = mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q          <= 1'b0;
      striped_q       <= 1'b0;
      lane_out_valid  <= 1'b0;
      lane_out_data   <= '0;
      ev_tx_underflow <= 1'b0;
      ev_rx_overflow  <= 1'b0;
    end else begin
      lane_out_valid  <= fire;
      ev_tx_underflow <= starved;
      ev_rx_overflow  <= busy_q && lane_in_valid && !rx_ready;
      if (fire) begin
        busy_q        <= 1'b1;
        striped_q     <= stripe_now && eff_multi;
        lane_out_data <= beat_w;
      end else if (busy_q && lane_in_valid) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign rx_valid = busy_q && lane_in_valid;
  assign rx_data  = striped_q ? rx_unstriped : DW'(lane_in_data[7:0]);
  assign rx_cnt   = striped_q ? CW'(MAX_LANES) : CW'(1);

  assert_pop_fits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (tx_valid && tx_avail >= tx_pop_cnt && tx_pop_cnt != '0));
  assert_beat_after_pop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    lane_out_valid |-> $past(tx_ready));
  assert_one_outstanding_R11: assert property (@(posedge clk) disable iff (!rst_n)
    lane_out_valid |=> !lane_out_valid);
  assert_underflow_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_underflow |-> !lane_out_valid);
  assert_overflow_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_overflow |-> $past(rx_valid && !rx_ready));
endmodule

// File: tb/tb_snp_lane_snooper.sv
`timescale 1ns/1ps
module tb_snp_lane_snooper;
  localparam int ML = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_change = 1'b0, cfg_sep_bus = 1'b1, cfg_two_mem = 1'b1;
  logic        xfer_req = 1'b0, tx_valid = 1'b0;
  logic [1:0]  tx_avail = '0;
  logic [15:0] tx_data = '0;
  logic        tx_ready;
  logic [1:0]  tx_pop_cnt;
  logic        lane_out_valid;
  logic [15:0] lane_out_data;
  logic        lane_in_valid = 1'b0;
  logic [15:0] lane_in_data = '0;
  logic        rx_valid, rx_ready = 1'b1;
  logic [15:0] rx_data;
  logic [1:0]  rx_cnt;
  logic        ev_tx_underflow, ev_rx_overflow;
  logic [1:0]  snoop_mode;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  snp_lane_snooper #(.MAX_LANES(ML)) dut (
    .clk(clk), .rst_n(rst_n), .cs_change(cs_change),
    .cfg_sep_bus(cfg_sep_bus), .cfg_two_mem(cfg_two_mem),
    .xfer_req(xfer_req), .tx_valid(tx_valid), .tx_avail(tx_avail), .tx_data(tx_data),
    .tx_ready(tx_ready), .tx_pop_cnt(tx_pop_cnt),
    .lane_out_valid(lane_out_valid), .lane_out_data(lane_out_data),
    .lane_in_valid(lane_in_valid), .lane_in_data(lane_in_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_cnt(rx_cnt),
    .ev_tx_underflow(ev_tx_underflow), .ev_rx_overflow(ev_rx_overflow),
    .snoop_mode(snoop_mode)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // lane k bit j = pair bit 2j+k
  function automatic logic [15:0] stripe2(input logic [15:0] p);
    logic [15:0] r = '0;
    for (int j = 0; j < 8; j++) begin
      r[j]     = p[2*j];
      r[8 + j] = p[2*j + 1];
    end
    return r;
  endfunction

  function automatic logic [15:0] unstripe2(input logic [15:0] l);
    logic [15:0] r = '0;
    for (int j = 0; j < 8; j++) begin
      r[2*j]     = l[j];
      r[2*j + 1] = l[8 + j];
    end
    return r;
  endfunction

  // one complete transfer; strp/e2 describe the state the bench expects
  task automatic xfer(input logic [7:0] b0, input logic [7:0] b1, input bit strp, input bit e2,
                      input bit rdy, input bit echo, input logic [15:0] fixed, input bit with_cs,
                      input string req);
    logic [15:0] exp_lane, reply, exp_rx;
    logic [1:0]  exp_pop, exp_cnt;
    exp_pop  = (strp && e2) ? 2'd2 : 2'd1;
    exp_lane = (strp && e2) ? stripe2({b1, b0}) : (e2 ? {b0, b0} : {8'h00, b0});
    @(negedge clk);
    xfer_req = 1'b1; tx_valid = 1'b1; tx_avail = 2'd2; tx_data = {b1, b0}; cs_change = with_cs;
    #1;
    chk(tx_ready && tx_pop_cnt == exp_pop, req, {30'd0, tx_pop_cnt}, {30'd0, exp_pop});
    @(negedge clk);
    xfer_req = 1'b0; tx_valid = 1'b0; cs_change = 1'b0;
    chk(lane_out_valid && lane_out_data == exp_lane, req, lane_out_data, exp_lane);
    reply = echo ? lane_out_data : fixed;
    exp_rx  = (strp && e2) ? unstripe2(reply) : {8'h00, reply[7:0]};
    exp_cnt = (strp && e2) ? 2'd2 : 2'd1;
    lane_in_valid = 1'b1; lane_in_data = reply; rx_ready = rdy;
    #1;
    chk(rx_valid && rx_data == exp_rx && rx_cnt == exp_cnt, req, {rx_cnt, 14'd0, rx_data}, {exp_cnt, 14'd0, exp_rx});
    @(negedge clk);
    lane_in_valid = 1'b0; rx_ready = 1'b1;
    chk(ev_rx_overflow == !rdy, req, {31'd0, ev_rx_overflow}, {31'd0, !rdy});
  endtask

  task automatic cs_pulse();
    @(negedge clk); cs_change = 1'b1;
    @(negedge clk); cs_change = 1'b0;
  endtask

  task automatic mode_is(input logic [1:0] m, input string req);
    chk(snoop_mode == m, req, {30'd0, snoop_mode}, {30'd0, m});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] ops [4];
    int         skips [4];
    ops[0] = 8'h03; skips[0] = 3;
    ops[1] = 8'h0B; skips[1] = 4;
    ops[2] = 8'hBB; skips[2] = 4;
    ops[3] = 8'hEB; skips[3] = 5;

    repeat (3) @(negedge clk);
    // R1 reset state
    mode_is(2'd0, "R1");
    chk(!lane_out_valid && !tx_ready && !ev_tx_underflow && !ev_rx_overflow, "R1",
        {lane_out_valid, tx_ready, ev_tx_underflow, ev_rx_overflow}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    mode_is(2'd0, "R1");

    // R3: each instruction, its skip count, then striping with R6/R7 round trip
    for (int i = 0; i < 4; i++) begin
      cs_pulse();
      mode_is(2'd0, "R2");
      xfer(ops[i], 8'h00, 0, 1, 1, 0, 16'hA55A, 0, "R5 opcode");
      mode_is(2'd1, "R3");
      for (int s = 0; s < skips[i]; s++) begin
        mode_is(2'd1, "R3 skipping");
        xfer(8'(8'h10 + s), 8'h00, 0, 1, 1, 0, 16'h3CC3, 0, "R5 skip byte");
      end
      mode_is(2'd2, "R3 striping");
      xfer(8'hC5, 8'h3A, 1, 1, 1, 1, 16'h0, 0, "R6 stripe");
    end

    // R7 fixed-pattern de-stripe: lane0 all ones -> even bits set
    xfer(8'h00, 8'h00, 1, 1, 1, 0, 16'h00FF, 0, "R7 even");
    xfer(8'h00, 8'h00, 1, 1, 1, 0, 16'hFF00, 0, "R7 odd");

    // R6/R7 sweep of the low byte with a derived high byte, echoing lanes
    for (int v = 0; v < 256; v++) begin
      xfer(8'(v), 8'(v * 37 + 11), 1, 1, 1, 1, 16'h0, 0, "R7 sweep");
    end
    mode_is(2'd2, "R3 sticky");

    // R9 underflow while striping with two lanes: one byte is not enough
    @(negedge clk);
    xfer_req = 1'b1; tx_valid = 1'b1; tx_avail = 2'd1; tx_data = 16'h0077;
    #1;
    chk(!tx_ready && tx_pop_cnt == 2'd0, "R9", {30'd0, tx_pop_cnt}, 0);
    @(negedge clk);
    xfer_req = 1'b0; tx_valid = 1'b0; tx_avail = 2'd0;
    chk(ev_tx_underflow && !lane_out_valid, "R9", {ev_tx_underflow, lane_out_valid}, 2'b10);
    mode_is(2'd2, "R9 mode kept");
    @(negedge clk);
    chk(!ev_tx_underflow, "R9 pulse", {31'd0, ev_tx_underflow}, 0);

    // R10 overflow: reply dropped, mode unaffected
    xfer(8'h12, 8'h34, 1, 1, 0, 1, 16'h0, 0, "R10");
    mode_is(2'd2, "R10 mode kept");

    // R11: second request while busy is ignored
    @(negedge clk);
    xfer_req = 1'b1; tx_valid = 1'b1; tx_avail = 2'd2; tx_data = 16'h5566;
    @(negedge clk);
    #1;
    chk(busy_ignored(), "R11 busy", {31'd0, tx_ready}, 0);
    chk(lane_out_valid, "R11 latency", {31'd0, lane_out_valid}, 1);
    xfer_req = 1'b0; tx_valid = 1'b0;
    lane_in_valid = 1'b1; lane_in_data = 16'h0;
    @(negedge clk);
    lane_in_valid = 1'b0;
    chk(!lane_out_valid, "R11 single beat", {31'd0, lane_out_valid}, 0);

    // R4 unknown instruction, then known ones are not decoded
    cs_pulse();
    xfer(8'h9F, 8'h00, 0, 1, 1, 0, 16'h00AB, 0, "R4");
    mode_is(2'd3, "R4");
    for (int s = 0; s < 8; s++) begin
      xfer(8'h03, 8'h0B, 0, 1, 1, 0, 16'h1234, 0, "R4 no stripe");
    end
    mode_is(2'd3, "R4 sticky");

    // R2: chip-select change coinciding with a transfer wins
    xfer(8'h03, 8'h00, 0, 1, 1, 0, 16'h0001, 1, "R2 coincide");
    mode_is(2'd0, "R2 coincide");
    xfer(8'h03, 8'h00, 0, 1, 1, 0, 16'h0001, 0, "R2 decode");
    mode_is(2'd1, "R2 decode");

    // R8: the three single-lane configurations
    for (int c = 0; c < 3; c++) begin
      cfg_sep_bus = c[0]; cfg_two_mem = c[1];
      cs_pulse();
      xfer(8'h03, 8'h00, 0, 0, 1, 0, 16'hEE44, 0, "R8 opcode");
      for (int s = 0; s < 3; s++) xfer(8'h00, 8'h00, 0, 0, 1, 0, 16'h1111, 0, "R8 skip");
      mode_is(2'd2, "R8 striping");
      xfer(8'hA7, 8'h5C, 1, 0, 1, 0, 16'h99C3, 0, "R8 pass");
      // one byte is enough with one lane
      @(negedge clk);
      xfer_req = 1'b1; tx_valid = 1'b1; tx_avail = 2'd1; tx_data = 16'h0042;
      #1;
      chk(tx_ready && tx_pop_cnt == 2'd1, "R8 single pop", {30'd0, tx_pop_cnt}, 1);
      @(negedge clk);
      xfer_req = 1'b0; tx_valid = 1'b0;
      lane_in_valid = 1'b1; lane_in_data = 16'h0042;
      @(negedge clk);
      lane_in_valid = 1'b0;
    end
    cfg_sep_bus = 1'b1; cfg_two_mem = 1'b1;

    // R9 empty transmit side outside striping
    cs_pulse();
    @(negedge clk);
    xfer_req = 1'b1; tx_valid = 1'b0; tx_avail = 2'd0;
    @(negedge clk);
    xfer_req = 1'b0;
    chk(ev_tx_underflow && !lane_out_valid, "R9 empty", {ev_tx_underflow, lane_out_valid}, 2'b10);
    mode_is(2'd0, "R9 empty mode");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  function automatic bit busy_ignored();
    return !tx_ready && tx_pop_cnt == 2'd0;
  endfunction
endmodule